// File: doc/BRIEF.md
# Width-Adaptive Byte Enable Sequencer

This block produces the four active-low byte-lane strobes and the active-low data-enable strobe for an external multiplexed address/data bus controller. Each access targets a region configured as 8, 16 or 32 bits wide. Once the block takes a request, the meaning of the strobe pins depends on that width. On a 32-bit region all four pins are lane selects. On a 16-bit region two pins are lane selects, one is parked high and one carries address bit A1. On an 8-bit region two pins are parked high and two carry A1:A0. Wherever a pin carries an address bit, that address moves forward each time the ready input is sampled high.

A request gives a start address, a width code, a mode bit, a lane mask, a burst length and a byte count. In core mode the lane mask stays fixed and the access lasts for the programmed number of beats. In DMA mode the lanes are worked out again for every beat from the current address and the bytes still left, and the access ends when the byte count is used up. Every access runs through one address cycle and then a data phase. The data phase lasts until the ready that completes the last beat, and the block then returns to idle.

Top module: `be_seq_top`

## Requirements
- R1: Width code `req_width_i` selects 8-bit for 2'b00, 16-bit for 2'b01, and 32-bit for both 2'b10 and 2'b11.
- R2: On a 32-bit region, `be_no[k]` low enables data bits 8k+7:8k. In core mode `be_no` equals `~req_mask_i` and holds that value over every beat of the burst.
- R3: On a 16-bit region, `be_no[3]` low enables the high byte (data 15:8) and `be_no[0]` low enables the low byte (data 7:0). In core mode these follow mask bits 1 and 0. `be_no[2]` is held at 1 and `be_no[1]` carries address bit A1.
- R4: On an 8-bit region, `be_no[3:2]` is held at 2'b11 and `be_no[1:0]` carries address bits A1:A0.
- R5: In core mode on a narrow region, the address on the pins moves forward by one bus unit after each sampled ready: A1 toggles on a 16-bit region, and A1:A0 counts up modulo 4 on an 8-bit region.
- R6: In DMA mode the access moves `req_count_i`+1 bytes and `req_beats_i` is ignored. Each beat enables the bytes from the current offset within the bus unit up to the end of the unit or the end of the count, whichever comes first. The next beat starts at the byte after the last one enabled.
- R7: In core mode an access ends after `req_beats_i`+1 sampled readies.
- R8: The cycle after a request is accepted is one address cycle: the enables are driven and `den_no` is 1. Data cycles follow with `den_no` at 0 until the cycle in which ready completes the last beat. The next cycle is idle.
- R9: In reset and in idle, `be_no` is 4'hF, `den_no` is 1 and `req_ready_o` is 1.
- R10: `req_ready_o` is 0 during address and data cycles. A request presented then is ignored and does not change the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block is idle and takes a request |
| req_addr_i | input | ADDR_W | Start byte address |
| req_width_i | input | 2 | Region width code |
| req_dma_i | input | 1 | 1: DMA mode (per-beat lanes), 0: core mode |
| req_mask_i | input | 4 | Core-mode lane mask, bit k = byte lane k |
| req_count_i | input | CNT_W | DMA byte count minus one |
| req_beats_i | input | BEAT_W | Core-mode beat count minus one |
| rdy_i | input | 1 | Ready acknowledge for the current data beat |
| be_no | output | 4 | Byte enables / narrow-bus address bits |
| den_no | output | 1 | Data enable, low in data cycles |

## Verification
The assertions assume that `rdy_i` carries meaning only in data cycles and that the request fields are steady while `req_valid_i` is high in idle. They also assume that a core-mode narrow burst is not expected to carry into address bits above A1. The stimulus raises ready only in data cycles and holds each request steady for its accept cycle. During busy cycles it deliberately presents conflicting requests to exercise R10. Ready stalls of zero to several cycles are applied between beats so that address stepping is seen both with and without gaps.

// File: rtl/be_seq_pkg.sv
package be_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    BW_8  = 2'b00,
    BW_16 = 2'b01,
    BW_32 = 2'b10
  } bw_e;

  function automatic logic [2:0] unit_bytes(bw_e bw);
    case (bw)
      BW_32:   return 3'd4;
      BW_16:   return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/be_width_dec.sv
module be_width_dec
  import be_seq_pkg::*;
(
  input  logic [1:0] code_i,
  output bw_e        bw_o
);
  always_comb begin
    case (code_i)
      2'b00:   bw_o = BW_8;
      2'b01:   bw_o = BW_16;
      default: bw_o = BW_32;  // 2'b11 folds onto 32-bit
    endcase
  end
endmodule

// File: rtl/be_lane_gen.sv
module be_lane_gen
  import be_seq_pkg::*;
#(
  parameter int REM_W = 9
) (
  input  bw_e              bw_i,
  input  logic             dma_i,
  input  logic [1:0]       off_addr_i,
  input  logic [REM_W-1:0] rem_i,
  input  logic [3:0]       mask_i,
  output logic [3:0]       lanes_o,
  output logic [2:0]       step_o,
  output logic             dma_last_o
);
  localparam int NLANE = 4;

  logic [2:0] unit;
  logic [1:0] off;
  logic [2:0] room;
  logic [2:0] n;
  logic       rem_short;
  logic [NLANE-1:0] dma_lanes;

  always_comb begin
    unit = unit_bytes(bw_i);
    case (bw_i)
      BW_32:   off = off_addr_i;
      BW_16:   off = {1'b0, off_addr_i[0]};
      default: off = 2'b00;
    endcase
    room      = unit - {1'b0, off};
    rem_short = (rem_i < REM_W'(room));
    n         = rem_short ? rem_i[2:0] : room;
  end

  // contiguous run of n lanes starting at the unit offset
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign dma_lanes[g] = (3'(g) >= {1'b0, off}) && (3'(g) < ({1'b0, off} + n));
  end

  assign lanes_o    = dma_i ? dma_lanes : mask_i;
  assign step_o     = dma_i ? n : unit;
  assign dma_last_o = (rem_i <= REM_W'(room));
endmodule

// File: rtl/be_pin_map.sv
module be_pin_map
  import be_seq_pkg::*;
(
  input  phase_e     ph_i,
  input  bw_e        bw_i,
  input  logic [3:0] lanes_i,
  input  logic [1:0] addr_lo_i,
  output logic [3:0] be_no,
  output logic       den_no
);
  always_comb begin
    if (ph_i == PH_IDLE) begin
      be_no = 4'hF;
    end else begin
      case (bw_i)
        BW_32:   be_no = ~lanes_i;
        BW_16:   be_no = {~lanes_i[1], 1'b1, addr_lo_i[1], ~lanes_i[0]};
        default: be_no = {2'b11, addr_lo_i};
      endcase
    end
    den_no = (ph_i != PH_DATA);
  end
endmodule

// File: rtl/be_phase_ctrl.sv
module be_phase_ctrl
  import be_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int BEAT_W = 4,
  localparam int REM_W = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  bw_e               req_bw_i,
  input  logic              req_dma_i,
  input  logic [3:0]        req_mask_i,
  input  logic [CNT_W-1:0]  req_count_i,
  input  logic [BEAT_W-1:0] req_beats_i,
  input  logic              rdy_i,
  input  logic [2:0]        step_i,
  input  logic              dma_last_i,
  output phase_e            ph_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [REM_W-1:0]  rem_o,
  output bw_e               bw_o,
  output logic              dma_o,
  output logic [3:0]        mask_o,
  output logic              last_o,
  output logic              req_ready_o
);
  phase_e            ph_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REM_W-1:0]  rem_q;
  logic [BEAT_W-1:0] beats_q;
  bw_e               bw_q;
  logic              dma_q;
  logic [3:0]        mask_q;
  logic              last_beat;

  assign last_beat = dma_q ? dma_last_i : (beats_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      beats_q <= '0;
      bw_q    <= BW_32;
      dma_q   <= 1'b0;
      mask_q  <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (req_valid_i) begin
            ph_q    <= PH_ADDR;
            addr_q  <= req_addr_i;
            rem_q   <= REM_W'(req_count_i) + REM_W'(1);
            beats_q <= req_beats_i;
            bw_q    <= req_bw_i;
            dma_q   <= req_dma_i;
            mask_q  <= req_mask_i;
          end
        end
        PH_ADDR: ph_q <= PH_DATA;
        PH_DATA: begin
          if (rdy_i) begin
            if (last_beat) begin
              ph_q <= PH_IDLE;
            end else begin
              addr_q  <= addr_q + ADDR_W'(step_i);
              beats_q <= beats_q - BEAT_W'(1);
              if (dma_q) rem_q <= rem_q - REM_W'(step_i);
            end
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign ph_o        = ph_q;
  assign addr_o      = addr_q;
  assign rem_o       = rem_q;
  assign bw_o        = bw_q;
  assign dma_o       = dma_q;
  assign mask_o      = mask_q;
  assign last_o      = last_beat;
  assign req_ready_o = (ph_q == PH_IDLE);
endmodule

// File: rtl/be_seq_top.sv
module be_seq_top
  import be_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int BEAT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_width_i,
  input  logic              req_dma_i,
  input  logic [3:0]        req_mask_i,
  input  logic [CNT_W-1:0]  req_count_i,
  input  logic [BEAT_W-1:0] req_beats_i,
  input  logic              rdy_i,
  output logic [3:0]        be_no,
  output logic              den_no
);
  localparam int REM_W = CNT_W + 1;

  bw_e               req_bw;
  phase_e            ph;
  logic [ADDR_W-1:0] addr_q;
  logic [REM_W-1:0]  rem_q;
  bw_e               bw_q;
  logic              dma_q;
  logic [3:0]        mask_q;
  logic              last_beat;
  logic [3:0]        lanes;
  logic [2:0]        step;
  logic              dma_last;

  be_width_dec u_dec (
    .code_i (req_width_i),
    .bw_o   (req_bw)
  );

  be_phase_ctrl #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .BEAT_W (BEAT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_bw_i    (req_bw),
    .req_dma_i   (req_dma_i),
    .req_mask_i  (req_mask_i),
    .req_count_i (req_count_i),
    .req_beats_i (req_beats_i),
    .rdy_i       (rdy_i),
    .step_i      (step),
    .dma_last_i  (dma_last),
    .ph_o        (ph),
    .addr_o      (addr_q),
    .rem_o       (rem_q),
    .bw_o        (bw_q),
    .dma_o       (dma_q),
    .mask_o      (mask_q),
    .last_o      (last_beat),
    .req_ready_o (req_ready_o)
  );

  be_lane_gen #(
    .REM_W (REM_W)
  ) u_lane (
    .bw_i       (bw_q),
    .dma_i      (dma_q),
    .off_addr_i (addr_q[1:0]),
    .rem_i      (rem_q),
    .mask_i     (mask_q),
    .lanes_o    (lanes),
    .step_o     (step),
    .dma_last_o (dma_last)
  );

  be_pin_map u_pins (
    .ph_i      (ph),
    .bw_i      (bw_q),
    .lanes_i   (lanes),
    .addr_lo_i (addr_q[1:0]),
    .be_no     (be_no),
    .den_no    (den_no)
  );
endmodule

// File: rtl/be_seq_chk.sv
module be_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic [3:0] be_no,
  input logic       den_no,
  input logic       rdy_i,
  input logic [1:0] bw_q,
  input logic       dma_q,
  input logic       last_beat
);
  a_r9_idle_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (be_no == 4'hF && den_no));

  a_r8_addr_cycle_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(den_no) |-> $past(!req_ready_o));

  a_r8_end_on_last_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(den_no) |-> $past(rdy_i && last_beat));

  a_r2_core32_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!den_no && $past(!den_no) && bw_q == 2'b10 && !dma_q) |-> $stable(be_no));

  a_r5_byte_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!den_no && rdy_i && !last_beat && bw_q == 2'b00 && !dma_q)
      |=> (be_no[1:0] == $past(be_no[1:0]) + 2'd1));

  a_r4_byte_hi_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && bw_q == 2'b00) |-> (be_no[3:2] == 2'b11));

  a_r10_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> ($stable(bw_q) && $stable(dma_q)));
endmodule

bind be_seq_top be_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .be_no       (be_no),
  .den_no      (den_no),
  .rdy_i       (rdy_i),
  .bw_q        (bw_q),
  .dma_q       (dma_q),
  .last_beat   (last_beat)
);

// File: tb/tb_be_seq_top.sv
`timescale 1ns/1ps
module tb_be_seq_top;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 8;
  localparam int BEAT_W = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [1:0]        req_width_i = '0;
  logic              req_dma_i = 1'b0;
  logic [3:0]        req_mask_i = '0;
  logic [CNT_W-1:0]  req_count_i = '0;
  logic [BEAT_W-1:0] req_beats_i = '0;
  logic              rdy_i = 1'b0;
  logic [3:0]        be_no;
  logic              den_no;

  always #2 clk = ~clk;

  be_seq_top #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_W(BEAT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_width_i(req_width_i), .req_dma_i(req_dma_i),
    .req_mask_i(req_mask_i), .req_count_i(req_count_i), .req_beats_i(req_beats_i),
    .rdy_i(rdy_i), .be_no(be_no), .den_no(den_no)
  );

  typedef struct packed {
    logic [3:0] be;
    logic       den;
    logic       rdy;
  } exp_t;

  exp_t  sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_tag = "R9";
  bit    done = 1'b0;

  // spec model of one beat's pins and its byte step
  task automatic model_beat(input int u, input bit dma, input logic [31:0] a, input int rem,
                            input logic [3:0] mask, output logic [3:0] be, output int n);
    int off;
    logic [3:0] lanes;
    off = int'(a) % u;
    lanes = 4'h0;
    if (dma) begin
      n = (rem < u - off) ? rem : (u - off);
      for (int i = 0; i < 4; i++) if (i >= off && i < off + n) lanes[i] = 1'b1;
    end else begin
      n = u;
      lanes = mask;
    end
    if (u == 4)      be = ~lanes;
    else if (u == 2) be = {~lanes[1], 1'b1, a[1], ~lanes[0]};
    else             be = {2'b11, a[1], a[0]};
  endtask

  task automatic push(input logic [3:0] be, input logic den, input logic rdy);
    exp_t e;
    e.be = be; e.den = den; e.rdy = rdy;
    sb_q.push_back(e);
  endtask

  // driver: called shortly after a rising edge while idle
  task automatic run_req(input logic [1:0] wc, input bit dma, input logic [31:0] addr,
                         input logic [3:0] mask, input int cnt, input int beats,
                         input int stall, input bit noise, input string tag);
    int u, rem, nb, n;
    logic [31:0] a;
    logic [3:0] be;
    logic [3:0] bes[$];
    u = (wc == 2'b00) ? 1 : (wc == 2'b01) ? 2 : 4;
    a = addr;
    rem = cnt + 1;
    nb = beats + 1;
    while (dma ? (rem > 0) : (nb > 0)) begin
      model_beat(u, dma, a, rem, mask, be, n);
      bes.push_back(be);
      a = a + 32'(n);
      rem = rem - n;
      nb = nb - 1;
    end
    cur_tag = tag;
    push(4'hF, 1'b1, 1'b1);
    push(bes[0], 1'b1, 1'b0);
    foreach (bes[k]) for (int s = 0; s <= stall; s++) push(bes[k], 1'b0, 1'b0);
    push(4'hF, 1'b1, 1'b1);

    req_width_i = wc; req_dma_i = dma; req_addr_i = addr; req_mask_i = mask;
    req_count_i = CNT_W'(cnt); req_beats_i = BEAT_W'(beats); req_valid_i = 1'b1;
    @(posedge clk); #1;
    if (noise) begin  // R10: conflicting request while busy
      req_width_i = ~wc; req_dma_i = ~dma; req_addr_i = 32'h5555_5557;
      req_mask_i = ~mask; req_count_i = '1; req_beats_i = '1;
    end else begin
      req_valid_i = 1'b0;
    end
    rdy_i = 1'b0;
    foreach (bes[k]) begin
      for (int s = 0; s < stall; s++) begin @(posedge clk); #1; rdy_i = 1'b0; end
      @(posedge clk); #1; rdy_i = 1'b1;
    end
    @(posedge clk); #1;
    rdy_i = 1'b0; req_valid_i = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!done && sb_q.size() > 0) begin
      exp_t e, got;
      e = sb_q.pop_front();
      got.be = be_no; got.den = den_no; got.rdy = req_ready_o;
      n_cmp++;
      if (got !== e) begin
        n_bad++;
        $display("FAIL %s: be=%b den=%b ready=%b expected be=%b den=%b ready=%b",
                 cur_tag, got.be, got.den, got.rdy, e.be, e.den, e.rdy);
      end
    end
  end

  initial begin
    #(4 * 20000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    n_cmp++;
    if (be_no !== 4'hF || den_no !== 1'b1 || req_ready_o !== 1'b1) begin
      n_bad++;
      $display("FAIL R9 reset: be=%b den=%b ready=%b expected be=1111 den=1 ready=1",
               be_no, den_no, req_ready_o);
    end
    rst_ni = 1'b1;
    @(posedge clk); #1;

    // R2 R7 R8: 32-bit core burst, all lanes, 4 beats, one-cycle stalls
    run_req(2'b10, 1'b0, 32'h100, 4'hF, 0, 3, 1, 1'b0, "R2/R7/R8 core32 full");
    // R2 R10: partial mask, busy-time conflicting request
    run_req(2'b10, 1'b0, 32'h104, 4'h6, 0, 1, 0, 1'b1, "R2/R10 core32 mask6");
    // R6: 32-bit DMA, 9 bytes from offset 1 -> 1110, 1111, 0011
    run_req(2'b10, 1'b1, 32'h201, 4'h0, 8, 7, 0, 1'b0, "R6 dma32 off1");
    // R3 R5: 16-bit core high byte only, A1 toggles
    run_req(2'b01, 1'b0, 32'h302, 4'h2, 0, 2, 2, 1'b0, "R3/R5 core16 hi");
    // R3 R6: 16-bit DMA, 4 bytes from odd address
    run_req(2'b01, 1'b1, 32'h301, 4'h0, 3, 9, 0, 1'b1, "R3/R6/R10 dma16");
    // R4 R5: 8-bit core, A1:A0 wraps 3,0,1,2,3
    run_req(2'b00, 1'b0, 32'h403, 4'hF, 0, 4, 0, 1'b0, "R4/R5 core8 wrap");
    // R4 R6: 8-bit DMA, 3 bytes
    run_req(2'b00, 1'b1, 32'h402, 4'h0, 2, 0, 1, 1'b0, "R4/R6 dma8");
    // R1: code 11 behaves as 32-bit
    run_req(2'b11, 1'b0, 32'h500, 4'h9, 0, 0, 0, 1'b0, "R1 code11");
    // R1: code 01 and code 00 with one-beat DMA
    run_req(2'b01, 1'b1, 32'h600, 4'h0, 1, 0, 0, 1'b0, "R1/R6 dma16 aligned");
    run_req(2'b00, 1'b1, 32'h601, 4'h0, 0, 5, 3, 1'b0, "R1/R6 dma8 single");
    // R6 R7: 32-bit DMA exactly one word, beats field ignored
    run_req(2'b10, 1'b1, 32'h700, 4'h1, 3, 15, 0, 1'b1, "R6/R7 dma32 word");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule